// File: doc/BRIEF.md
# Interval Cost-Benefit Threshold Tuner

This block tunes the miss threshold that a hybrid-memory controller uses to decide when a row is copied from the slow memory into the fast memory. Time is divided into quanta of a fixed number of clock cycles. During each quantum the block counts three kinds of event strobe: a completed migration, a read served by the fast memory and a write served by the fast memory.

On the last cycle of a quantum the block estimates the net benefit of the current threshold. The benefit is the cycles saved by serving reads and writes from the fast memory instead of the slow one. The cost is the cycles spent moving data. The block then moves the threshold one step by hill climbing on that figure. It also keeps the net benefit and the direction of the step for the next quantum. The per-operation latencies are parameters given in clock cycles.

The threshold output feeds the miss tracking logic directly. The reset input is expected to be already synchronized to `clk`.

Top module: `thresh_tuner`

## Requirements
- R1: While reset is asserted and after it is released, the threshold equals the parameter INIT_THRESH. The stored previous net benefit starts at 0 and the stored last step direction starts as "up".
- R2: The threshold changes only on the clock edge that ends a quantum. A quantum is QUANTUM consecutive cycles, starting with the first cycle after reset is released. Strobes on every cycle of a quantum, including its last, are counted toward it.
- R3: The net benefit is computed as signed 48-bit arithmetic: reads × (T_RD_SLOW − T_RD_FAST) + writes × (T_WR_SLOW − T_WR_FAST) − migrations × T_MIGRATE.
- R4: When the net benefit is negative, the step direction is up.
- R5: When the net benefit is zero or positive and strictly greater than the previous quantum's net benefit, the step repeats the direction of the last step.
- R6: In every other case the step reverses the direction of the last step. This includes a net benefit equal to the previous one.
- R7: At the end of every quantum, whichever branch was taken, the current net benefit replaces the stored previous net benefit.
- R8: The threshold stays within [TH_MIN, TH_MAX], which defaults to [1, 255]. A step that would cross a bound leaves the threshold at the bound, but the direction that was attempted is still recorded.
- R9: The event counts restart from zero in each quantum, so events from one quantum do not add to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mig_evt | input | 1 | One migration completed this cycle |
| fast_rd_evt | input | 1 | One read served by fast memory this cycle |
| fast_wr_evt | input | 1 | One write served by fast memory this cycle |
| thresh | output | TH_W (8) | Current migration miss threshold |

## Verification
The checker verifies these properties on every cycle:
- the threshold stays inside its bounds;
- the threshold holds between quantum ends;
- a negative net benefit produces an upward step;
- the repeat-direction and reverse-direction choices are made correctly;
- the previous net benefit is refreshed at each quantum end.

The correctness of the net-benefit arithmetic itself, the alignment of the quantum to reset and the clearing of the counts can only be shown by the bench scenarios. In those scenarios the threshold is predicted from event counts tallied in the bench. The scenarios include directed quanta that reach the lower bound, set up a tie with the previous net benefit and follow a negative quantum.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  localparam int NB_W = 48;
  typedef logic signed [NB_W-1:0] nb_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] total
);
  logic [W-1:0] cnt_q, cnt_d;

  // total includes the strobe of the current cycle
  assign total = cnt_q + W'(inc);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else if (inc) cnt_d = total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/benefit_calc.sv
module benefit_calc
  import tuner_pkg::*;
#(
  parameter int W         = 8,
  parameter int T_MIGRATE = 1000,
  parameter int T_RD_FAST = 80,
  parameter int T_RD_SLOW = 128,
  parameter int T_WR_FAST = 80,
  parameter int T_WR_SLOW = 368
) (
  input  logic [W-1:0] mig_n,
  input  logic [W-1:0] rd_n,
  input  logic [W-1:0] wr_n,
  output nb_t          net
);
  localparam nb_t D_RD = nb_t'(T_RD_SLOW - T_RD_FAST);
  localparam nb_t D_WR = nb_t'(T_WR_SLOW - T_WR_FAST);
  localparam nb_t C_MG = nb_t'(T_MIGRATE);

  nb_t mig_s, rd_s, wr_s;

  assign mig_s = nb_t'({{(NB_W-W){1'b0}}, mig_n});
  assign rd_s  = nb_t'({{(NB_W-W){1'b0}}, rd_n});
  assign wr_s  = nb_t'({{(NB_W-W){1'b0}}, wr_n});

  assign net = (rd_s * D_RD) + (wr_s * D_WR) - (mig_s * C_MG);
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
  import tuner_pkg::*;
#(
  parameter int TH_W   = 8,
  parameter int TH_MIN = 1,
  parameter int TH_MAX = 255,
  parameter int INIT   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  nb_t             net,
  output logic [TH_W-1:0] thresh,
  output logic            last_up,
  output nb_t             prev
);
  localparam logic [TH_W-1:0] MIN_V  = TH_W'(TH_MIN);
  localparam logic [TH_W-1:0] MAX_V  = TH_W'(TH_MAX);
  localparam logic [TH_W-1:0] INIT_V = TH_W'(INIT);

  logic [TH_W-1:0] th_q, th_d;
  logic            up_q, up_d;
  nb_t             prev_q, prev_d;
  logic            go_up;

  always_comb begin
    if (net < 0)           go_up = 1'b1;
    else if (net > prev_q) go_up = up_q;
    else                   go_up = ~up_q;

    th_d   = th_q;
    up_d   = up_q;
    prev_d = prev_q;
    if (en) begin
      up_d   = go_up;
      prev_d = net;
      if (go_up) th_d = (th_q >= MAX_V) ? MAX_V : th_q + 1'b1;
      else       th_d = (th_q <= MIN_V) ? MIN_V : th_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_q   <= INIT_V;
      up_q   <= 1'b1;
      prev_q <= '0;
    end else begin
      th_q   <= th_d;
      up_q   <= up_d;
      prev_q <= prev_d;
    end
  end

  assign thresh  = th_q;
  assign last_up = up_q;
  assign prev    = prev_q;
endmodule

// File: rtl/thresh_tuner.sv
module thresh_tuner
  import tuner_pkg::*;
#(
  parameter int QUANTUM     = 1024,
  parameter int TH_W        = 8,
  parameter int TH_MIN      = 1,
  parameter int TH_MAX      = 255,
  parameter int INIT_THRESH = 8,
  parameter int T_MIGRATE   = 1000,
  parameter int T_RD_FAST   = 80,
  parameter int T_RD_SLOW   = 128,
  parameter int T_WR_FAST   = 80,
  parameter int T_WR_SLOW   = 368
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mig_evt,
  input  logic            fast_rd_evt,
  input  logic            fast_wr_evt,
  output logic [TH_W-1:0] thresh
);
  localparam int QW    = (QUANTUM > 1) ? $clog2(QUANTUM) : 1;
  localparam int CNT_W = $clog2(QUANTUM + 1);
  localparam int N_EVT = 3;

  logic [QW-1:0] q_cnt, q_cnt_d;
  logic          q_end;

  assign q_end = (q_cnt == QW'(QUANTUM - 1));

  always_comb begin
    q_cnt_d = q_end ? '0 : q_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_cnt <= '0;
    else        q_cnt <= q_cnt_d;
  end

  // index 0: migration, 1: fast read, 2: fast write
  logic [N_EVT-1:0] evt_vec;
  logic [CNT_W-1:0] evt_tot [N_EVT];

  assign evt_vec = {fast_wr_evt, fast_rd_evt, mig_evt};

  for (genvar i = 0; i < N_EVT; i++) begin : g_cnt
    evt_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (q_end),
      .inc   (evt_vec[i]),
      .total (evt_tot[i])
    );
  end

  nb_t  net, prev;
  logic last_up;

  benefit_calc #(
    .W(CNT_W), .T_MIGRATE(T_MIGRATE),
    .T_RD_FAST(T_RD_FAST), .T_RD_SLOW(T_RD_SLOW),
    .T_WR_FAST(T_WR_FAST), .T_WR_SLOW(T_WR_SLOW)
  ) u_calc (
    .mig_n (evt_tot[0]),
    .rd_n  (evt_tot[1]),
    .wr_n  (evt_tot[2]),
    .net   (net)
  );

  step_ctrl #(
    .TH_W(TH_W), .TH_MIN(TH_MIN), .TH_MAX(TH_MAX), .INIT(INIT_THRESH)
  ) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (q_end),
    .net     (net),
    .thresh  (thresh),
    .last_up (last_up),
    .prev    (prev)
  );
endmodule

// File: rtl/thresh_tuner_chk.sv
module thresh_tuner_chk
  import tuner_pkg::*;
#(
  parameter int TH_W   = 8,
  parameter int TH_MIN = 1,
  parameter int TH_MAX = 255
) (
  input logic            clk,
  input logic            rst_n,
  input logic            q_end,
  input nb_t             net,
  input nb_t             prev,
  input logic            last_up,
  input logic [TH_W-1:0] thresh
);
  localparam logic [TH_W-1:0] MIN_V = TH_W'(TH_MIN);
  localparam logic [TH_W-1:0] MAX_V = TH_W'(TH_MAX);

  // R8
  thresh_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh >= MIN_V) && (thresh <= MAX_V));

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_end |=> $stable(thresh));

  // R4
  neg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_end && (net < 0)) |=>
      (last_up && (thresh == (($past(thresh) == MAX_V) ? MAX_V : $past(thresh) + 1'b1))));

  // R5
  same_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_end && (net >= 0) && (net > prev)) |=> (last_up == $past(last_up)));

  // R6
  flip_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_end && (net >= 0) && !(net > prev)) |=> (last_up != $past(last_up)));

  // R7
  prev_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_end |=> (prev == $past(net)));
endmodule

bind thresh_tuner thresh_tuner_chk #(
  .TH_W(TH_W), .TH_MIN(TH_MIN), .TH_MAX(TH_MAX)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .q_end   (q_end),
  .net     (net),
  .prev    (prev),
  .last_up (last_up),
  .thresh  (thresh)
);

// File: tb/sim_thresh_tuner.sv
module sim_thresh_tuner;
  localparam int CLK_P = 10;
  localparam int Q     = 32;
  localparam int INIT  = 2;
  localparam int TMG   = 100;
  localparam int RDF = 10, RDS = 30, WRF = 10, WRS = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mig = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] thresh;

  int total = 0;
  int bad   = 0;

  int      exp_th;
  bit      exp_up;
  longint  exp_prev;

  always #(CLK_P/2) clk = ~clk;

  thresh_tuner #(
    .QUANTUM(Q), .INIT_THRESH(INIT), .T_MIGRATE(TMG),
    .T_RD_FAST(RDF), .T_RD_SLOW(RDS), .T_WR_FAST(WRF), .T_WR_SLOW(WRS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mig_evt(mig),
    .fast_rd_evt(rd), .fast_wr_evt(wr), .thresh(thresh)
  );

  function automatic longint calc_net(int nm, int nr, int nw);
    return longint'(nr) * (RDS - RDF) + longint'(nw) * (WRS - WRF)
         - longint'(nm) * TMG;
  endfunction

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: thresh=%0d expected=%0d", req, act, expv);
    end
  endtask

  // rnd=0: first pm/pr/pw cycles carry the strobe; rnd=1: p/8 chance per cycle
  task automatic run_q(int pm, int pr, int pw, bit rnd);
    int nm = 0, nr = 0, nw = 0;
    longint net;
    bit go_up;
    string tag;
    for (int c = 0; c < Q; c++) begin
      if (rnd) begin
        mig = ($urandom_range(7, 0) < pm);
        rd  = ($urandom_range(7, 0) < pr);
        wr  = ($urandom_range(7, 0) < pw);
      end else begin
        mig = (c < pm); rd = (c < pr); wr = (c < pw);
      end
      nm += int'(mig); nr += int'(rd); nw += int'(wr);
      if (c == Q/2) check("R2 hold mid-quantum", int'(thresh), exp_th);
      @(negedge clk);
    end
    mig = 1'b0; rd = 1'b0; wr = 1'b0;
    net = calc_net(nm, nr, nw);
    if (net < 0) begin
      go_up = 1'b1; tag = "R4 R3 negative step";
    end else if (net > exp_prev) begin
      go_up = exp_up; tag = "R5 R3 R7 repeat direction";
    end else begin
      go_up = ~exp_up; tag = "R6 R3 R7 reverse direction";
    end
    if (go_up) exp_th = (exp_th >= 255) ? 255 : exp_th + 1;
    else       exp_th = (exp_th <= 1) ? 1 : exp_th - 1;
    exp_up   = go_up;
    exp_prev = net;
    check(tag, int'(thresh), exp_th);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_th = INIT; exp_up = 1'b1; exp_prev = 0;
    repeat (3) @(negedge clk);
    check("R1 reset value", int'(thresh), INIT);
    rst_n = 1'b1;
    check("R1 value at release", int'(thresh), INIT);
    // R1: idle quantum, net 0 not above prev 0, reverse of initial up -> 1
    run_q(0, 0, 0, 1'b0);
    check("R1 first step down", int'(thresh), 1);
    // R8: reads only, net > 0, repeat down, held at lower bound
    run_q(0, 8, 0, 1'b0);
    check("R8 lower bound hold", int'(thresh), 1);
    // R4: migrations only -> up to 2
    run_q(4, 0, 0, 1'b0);
    check("R4 negative net up", int'(thresh), 2);
    // R7: 640 > stored -400 -> repeat up -> 3
    run_q(0, Q, 0, 1'b0);
    check("R7 prev from negative quantum", int'(thresh), 3);
    // R9 R6: identical counts, equal net (counts restarted) -> reverse -> 2
    run_q(0, Q, 0, 1'b0);
    check("R9 R6 tie after clear", int'(thresh), 2);
    // writes plus the strobes on the last cycle of the quantum
    run_q(1, 0, Q, 1'b0);
    for (int k = 0; k < 18; k++)
      run_q($urandom_range(4, 0), $urandom_range(6, 0), $urandom_range(4, 0), 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule